// File: doc/BRIEF.md
# Serial Management Bus Command Master

This block lets a host reach the management registers of an external PHY through one 32-bit command/status word. Software fills in an opcode, a PHY address, a register address and, for a write, 16 data bits. It can write the word whole, as two halves or as single bytes under per-byte enables. The block launches a transaction only when the most-significant byte is part of the write. It then produces the management clock from the system clock, shifts a complete frame out on the data line, and for a read takes the data line back and shifts 16 bits into the data field.

When the frame ends, the block sets a ready flag in the word. If the interrupt-enable bit is set, an interrupt level is raised. That level stays up until software issues its next command, which writes the ready flag back to zero. A launch that carries a reserved opcode sends no frame and sets the ready flag at once. While a frame is in flight the word is frozen, and host writes to it are dropped.

Top module: `mgmt_cmd_master`

## Requirements
- R1: After reset, rd_data reads 0x00000000, and mdc, mdio_oe and irq are all 0.
- R2: Each of the four wr_be bits selects one byte lane of wr_data: bit b controls bits 8b+7:8b, and lanes whose enable bit is clear keep their value. Bits 31:30 always read 0. Field layout: bit 29 interrupt enable, bit 28 ready, bits 27:26 opcode, bits 25:21 PHY address, bits 20:16 register address, bits 15:0 data.
- R3: A write whose wr_be[3] is 0 never starts a frame: mdc stays 0 and mdio_oe stays 0.
- R4: A write with wr_be[3]=1 and a merged opcode of 01 (write) or 10 (read) starts a frame of exactly 64 MDC cycles. Each MDC cycle lasts 2*MDC_HALF_CLKS system clocks, and mdio_oe is 1 from the first bit.
- R5: The first 46 bits of a frame, each presented on mdio_o at a rising MDC edge, are: 32 ones, then 0 and 1, then the opcode, then the PHY address MSB first, then the register address MSB first.
- R6: On a write frame, bits 46 and 47 are 1 and 0, and bits 48 to 63 are data bits 15 down to 0. mdio_oe stays 1 for the whole frame.
- R7: On a read frame, mdio_oe is 0 from bit 46 to bit 63. mdio_i is sampled at the rising MDC edge of bits 48 to 63, and those 16 samples, first sample in bit 15, end up in rd_data[15:0].
- R8: Bit 28 reads back as written by the launching command during a frame. It becomes 1 on the system clock edge of the last falling MDC edge, which also ends the frame.
- R9: A launch whose merged opcode is 00 or 11 starts no frame and sets bit 28 on the same edge that stores the write.
- R10: irq equals bit 29 AND bit 28. It is therefore a level, and it drops once a new command writes bit 28 to 0.
- R11: While a frame is in flight, host writes are ignored and rd_data stays constant until the frame ends.
- R12: mdio_o and mdio_oe change only while mdc is low, so they hold steady across every cycle in which mdc is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Host write strobe, one cycle per write |
| wr_be | input | 4 | Byte lane enables for the write |
| wr_data | input | 32 | Host write data |
| rd_data | output | 32 | Current command/status word |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | Management data driven by the master |
| mdio_oe | output | 1 | Output enable for mdio_o |
| mdio_i | input | 1 | Management data returned from the PHY |
| irq | output | 1 | Completion interrupt level |

## Verification
The bench sweeps all sixteen byte-enable patterns against a model of the word. This targets two faults: a lane mask that leaks into a neighbouring byte, and a reserved-opcode launch that sends a frame or fails to set ready. Both would show up as a readback mismatch or a moving mdc. It then runs one frame for every PHY address, alternating reads and writes, and compares every header bit, the turnaround drive, the output-enable release and the MDC spacing. This catches a design that reverses a field, drives the line during a read turnaround, or samples the PHY on the wrong edge, because such a design returns scrambled read data. Two frames get a full-word write in mid-flight, which a design that fails to freeze the word would corrupt. Frames with the interrupt enabled back to back check that the interrupt level falls when the next command clears ready.

// File: rtl/mgmt_pkg.sv
package mgmt_pkg;
  localparam int unsigned PREAMBLE_LEN = 32;
  localparam int unsigned FRAME_LEN    = 64;
  localparam int unsigned TA_POS       = 46;
  localparam int unsigned DATA_POS     = 48;
  localparam int unsigned DATA_W       = 16;
  localparam int unsigned ADDR_W       = 5;
  localparam int unsigned WORD_W       = 32;
  localparam int unsigned LANES        = WORD_W / 8;

  localparam int unsigned BIT_IE  = 29;
  localparam int unsigned BIT_RDY = 28;
  localparam int unsigned OP_LSB  = 26;
  localparam int unsigned PHY_LSB = 21;
  localparam int unsigned REG_LSB = 16;

  localparam logic [1:0] OP_WRITE = 2'b01;
  localparam logic [1:0] OP_READ  = 2'b10;
endpackage

// File: rtl/mdc_divider.sv
module mdc_divider #(
  parameter int unsigned HALF_CLKS = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic mdc,
  output logic rise_ce,
  output logic fall_ce
);
  localparam int unsigned CW = (HALF_CLKS > 1) ? $clog2(HALF_CLKS) : 1;
  localparam logic [CW-1:0] CNT_TOP = CW'(HALF_CLKS - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          mdc_q, mdc_d;
  logic          tick;

  always_comb begin
    tick  = run && (cnt_q == CNT_TOP);
    cnt_d = cnt_q;
    mdc_d = mdc_q;
    if (!run) begin
      cnt_d = '0;
      mdc_d = 1'b0;
    end else if (tick) begin
      cnt_d = '0;
      mdc_d = ~mdc_q;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      mdc_q <= mdc_d;
    end
  end

  assign mdc     = mdc_q;
  assign rise_ce = tick & ~mdc_q;
  assign fall_ce = tick &  mdc_q;
endmodule

// File: rtl/frame_seq.sv
module frame_seq
  import mgmt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [1:0]        op,
  input  logic [ADDR_W-1:0] phy_addr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rise_ce,
  input  logic              fall_ce,
  input  logic              mdio_i,
  output logic              busy,
  output logic              done,
  output logic              is_read,
  output logic              mdio_o,
  output logic              mdio_oe,
  output logic [DATA_W-1:0] rdata
);
  localparam int unsigned IDX_W = $clog2(FRAME_LEN);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_LEN - 1);
  localparam logic [IDX_W-1:0] TA_IDX   = IDX_W'(TA_POS);
  localparam logic [IDX_W-1:0] DAT_IDX  = IDX_W'(DATA_POS);

  logic                 busy_q, busy_d;
  logic                 rd_q, rd_d;
  logic [IDX_W-1:0]     idx_q, idx_d;
  logic [FRAME_LEN-1:0] sh_q, sh_d;
  logic [DATA_W-1:0]    cap_q, cap_d;
  logic                 last_fall;

  always_comb begin
    busy_d    = busy_q;
    rd_d      = rd_q;
    idx_d     = idx_q;
    sh_d      = sh_q;
    cap_d     = cap_q;
    last_fall = busy_q && fall_ce && (idx_q == LAST_IDX);
    if (start && !busy_q) begin
      busy_d = 1'b1;
      rd_d   = (op == OP_READ);
      idx_d  = '0;
      cap_d  = '0;
      sh_d   = {{PREAMBLE_LEN{1'b1}}, 2'b01, op, phy_addr, reg_addr, 2'b10,
                (op == OP_READ) ? {DATA_W{1'b0}} : wdata};
    end else if (busy_q) begin
      if (rise_ce && rd_q && (idx_q >= DAT_IDX))
        cap_d = {cap_q[DATA_W-2:0], mdio_i};
      if (last_fall) begin
        busy_d = 1'b0;
      end else if (fall_ce) begin
        idx_d = idx_q + 1'b1;
        sh_d  = {sh_q[FRAME_LEN-2:0], 1'b0};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      rd_q   <= 1'b0;
      idx_q  <= '0;
      sh_q   <= '0;
      cap_q  <= '0;
    end else begin
      busy_q <= busy_d;
      rd_q   <= rd_d;
      idx_q  <= idx_d;
      sh_q   <= sh_d;
      cap_q  <= cap_d;
    end
  end

  assign busy    = busy_q;
  assign done    = last_fall;
  assign is_read = rd_q;
  assign mdio_o  = sh_q[FRAME_LEN-1];
  assign mdio_oe = busy_q && !(rd_q && (idx_q >= TA_IDX));
  assign rdata   = cap_q;
endmodule

// File: rtl/cmd_regfile.sv
module cmd_regfile
  import mgmt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [LANES-1:0]  wr_be,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              busy,
  input  logic              done,
  input  logic              done_read,
  input  logic [DATA_W-1:0] rdata,
  output logic [WORD_W-1:0] word,
  output logic [WORD_W-1:0] merged,
  output logic              start,
  output logic              irq
);
  logic [WORD_W-1:0] word_q, word_d;
  logic              accept, launch, op_ok;

  for (genvar b = 0; b < LANES; b++) begin : g_lane
    assign merged[8*b +: 8] = wr_be[b] ? wr_data[8*b +: 8] : word_q[8*b +: 8];
  end

  always_comb begin
    accept = wr_en && !busy;
    launch = accept && wr_be[LANES-1];
    op_ok  = (merged[OP_LSB +: 2] == OP_WRITE) || (merged[OP_LSB +: 2] == OP_READ);
    start  = launch && op_ok;
    word_d = word_q;
    if (accept) begin
      word_d = merged;
      if (launch && !op_ok) word_d[BIT_RDY] = 1'b1;
    end
    if (done) begin
      word_d[BIT_RDY] = 1'b1;
      if (done_read) word_d[DATA_W-1:0] = rdata;
    end
    word_d[WORD_W-1:WORD_W-2] = 2'b00;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) word_q <= '0;
    else        word_q <= word_d;
  end

  assign word = word_q;
  assign irq  = word_q[BIT_IE] & word_q[BIT_RDY];
endmodule

// File: rtl/mgmt_cmd_master.sv
module mgmt_cmd_master
  import mgmt_pkg::*;
#(
  parameter int unsigned MDC_HALF_CLKS = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [3:0]  wr_be,
  input  logic [31:0] wr_data,
  output logic [31:0] rd_data,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i,
  output logic        irq
);
  logic              rst_s0, rst_q_n;
  logic              seq_busy, seq_done, seq_read, seq_start;
  logic              rise_ce, fall_ce;
  logic [WORD_W-1:0] merged;
  logic [DATA_W-1:0] cap_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s0  <= 1'b0;
      rst_q_n <= 1'b0;
    end else begin
      rst_s0  <= 1'b1;
      rst_q_n <= rst_s0;
    end
  end

  cmd_regfile u_regs (
    .clk       (clk),
    .rst_n     (rst_q_n),
    .wr_en     (wr_en),
    .wr_be     (wr_be),
    .wr_data   (wr_data),
    .busy      (seq_busy),
    .done      (seq_done),
    .done_read (seq_read),
    .rdata     (cap_data),
    .word      (rd_data),
    .merged    (merged),
    .start     (seq_start),
    .irq       (irq)
  );

  mdc_divider #(.HALF_CLKS(MDC_HALF_CLKS)) u_div (
    .clk     (clk),
    .rst_n   (rst_q_n),
    .run     (seq_busy),
    .mdc     (mdc),
    .rise_ce (rise_ce),
    .fall_ce (fall_ce)
  );

  frame_seq u_seq (
    .clk      (clk),
    .rst_n    (rst_q_n),
    .start    (seq_start),
    .op       (merged[OP_LSB +: 2]),
    .phy_addr (merged[PHY_LSB +: ADDR_W]),
    .reg_addr (merged[REG_LSB +: ADDR_W]),
    .wdata    (merged[DATA_W-1:0]),
    .rise_ce  (rise_ce),
    .fall_ce  (fall_ce),
    .mdio_i   (mdio_i),
    .busy     (seq_busy),
    .done     (seq_done),
    .is_read  (seq_read),
    .mdio_o   (mdio_o),
    .mdio_oe  (mdio_oe),
    .rdata    (cap_data)
  );
endmodule

// File: rtl/mgmt_cmd_checker.sv
module mgmt_cmd_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        done,
  input logic [31:0] rd_data,
  input logic        mdc,
  input logic        mdio_o,
  input logic        mdio_oe
);
  // R3: no management clock without a frame in flight
  p_mdc_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdc);

  // R4: output enable only inside a frame
  p_oe_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdio_oe);

  // R4: the end of a frame only happens while one is running
  p_done_in_frame_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);

  // R8: frame end leaves ready set
  p_ready_after_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> rd_data[28]);

  // R11: the word is frozen while a frame runs
  p_word_frozen_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> $stable(rd_data));

  // R12: data line steady while mdc is high
  p_mdio_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    mdc |-> ($stable(mdio_o) && $stable(mdio_oe)));
endmodule

bind mgmt_cmd_master mgmt_cmd_checker u_chk (
  .clk     (clk),
  .rst_n   (rst_q_n),
  .busy    (seq_busy),
  .done    (seq_done),
  .rd_data (rd_data),
  .mdc     (mdc),
  .mdio_o  (mdio_o),
  .mdio_oe (mdio_oe)
);

// File: tb/sim_mgmt_cmd_master.sv
`timescale 1ns/1ps
module sim_mgmt_cmd_master;
  localparam int HALF = 2;
  localparam int CLK_NS = 4;
  localparam int WD_CYCLES = 150000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [3:0]  wr_be;
  logic [31:0] wr_data;
  logic [31:0] rd_data;
  logic        mdc, mdio_o, mdio_oe, mdio_i, irq;

  int checks = 0;
  int fails  = 0;

  always #(CLK_NS/2) clk = ~clk;

  mgmt_cmd_master #(.MDC_HALF_CLKS(HALF)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_be(wr_be), .wr_data(wr_data),
    .rd_data(rd_data), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .mdio_i(mdio_i), .irq(irq)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    wr_en = 1'b1; wr_be = be; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_be = 4'h0;
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    fails++;
    $display("FAIL R4 watchdog actual=%0d expected<%0d", WD_CYCLES, WD_CYCLES);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  task automatic run_frame(input logic [1:0] op, input logic [4:0] phy,
                           input logic [4:0] ra, input logic [15:0] data,
                           input logic ie, input logic [15:0] rdp, input logic mid);
    logic        is_rd;
    logic [63:0] expf;
    logic [31:0] cmd, exp_word;
    logic        bit_o, bit_oe, exp_oe;
    int hdr_err, tail_err, oe_err, per_err, hold_err;
    time tprev;
    is_rd = (op == 2'b10);
    hdr_err = 0; tail_err = 0; oe_err = 0; per_err = 0; hold_err = 0; tprev = 0;
    expf = {32'hFFFF_FFFF, 2'b01, op, phy, ra, 2'b10, data};
    cmd  = {2'b00, ie, 1'b0, op, phy, ra, is_rd ? 16'h0000 : data};
    reg_write(cmd, 4'hF);
    chk("R8 ready cleared by launch", {63'd0, rd_data[28]}, 64'd0);
    chk("R10 irq drops on new command", {63'd0, irq}, 64'd0);
    chk("R4 oe on at first bit", {63'd0, mdio_oe}, 64'd1);
    for (int k = 0; k < 64; k++) begin
      mdio_i = (k >= 48) ? rdp[63-k] : 1'b1;
      @(posedge mdc);
      #1;
      bit_o = mdio_o; bit_oe = mdio_oe;
      exp_oe = !(is_rd && k >= 46);
      if (bit_oe !== exp_oe) oe_err++;
      if (k < 46) begin
        if (bit_o !== expf[63-k]) hdr_err++;
      end else if (!is_rd && bit_o !== expf[63-k]) tail_err++;
      if (k > 0 && ($time - tprev) != time'(2*HALF*CLK_NS)) per_err++;
      tprev = $time;
      @(posedge clk);
      #1;
      if (mdio_o !== bit_o || mdio_oe !== bit_oe || mdc !== 1'b1) hold_err++;
      if (mid && k == 20) reg_write(32'hFFFF_FFFF, 4'hF);
    end
    chk("R5 header bits", 64'(hdr_err), 64'd0);
    chk("R4 MDC period", 64'(per_err), 64'd0);
    chk("R12 mdio steady while mdc high", 64'(hold_err), 64'd0);
    if (is_rd) chk("R7 oe released from turnaround", 64'(oe_err), 64'd0);
    else begin
      chk("R6 turnaround and data bits", 64'(tail_err), 64'd0);
      chk("R4 R6 oe held whole frame", 64'(oe_err), 64'd0);
    end
    repeat (3) @(negedge clk);
    exp_word = {2'b00, ie, 1'b1, op, phy, ra, is_rd ? rdp : data};
    if (mid) chk("R11 busy write ignored", 64'(rd_data), 64'(exp_word));
    else if (is_rd) chk("R7 R8 read result", 64'(rd_data), 64'(exp_word));
    else chk("R8 write result", 64'(rd_data), 64'(exp_word));
    chk("R10 irq level", {63'd0, irq}, {63'd0, ie});
    chk("R4 idle after frame", {62'd0, mdc, mdio_oe}, 64'd0);
  endtask

  initial begin
    logic [31:0] model, wd;
    rst_n = 1'b0; wr_en = 1'b0; wr_be = 4'h0; wr_data = '0; mdio_i = 1'b1;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 reset word", 64'(rd_data), 64'd0);
    chk("R1 reset pins", {61'd0, mdc, mdio_oe, irq}, 64'd0);

    model = '0;
    for (int be = 0; be < 16; be++) begin
      wd = (32'(be) * 32'h1111_1111) ^ 32'h5A5A_5A5A;
      wd[27:26] = be[0] ? 2'b11 : 2'b00;
      for (int b = 0; b < 4; b++)
        if (be[b]) model[8*b +: 8] = wd[8*b +: 8];
      model[31:30] = 2'b00;
      if (be[3]) model[28] = 1'b1;
      reg_write(wd, 4'(be));
      chk(be[3] ? "R2 R9 lane merge reserved launch" : "R2 lane merge",
          64'(rd_data), 64'(model));
      chk("R10 irq follows word", {63'd0, irq}, {63'd0, model[29] & model[28]});
      repeat (4*HALF + 2) @(negedge clk);
      chk(be[3] ? "R9 reserved op sends no frame" : "R3 no launch without top byte",
          {62'd0, mdc, mdio_oe}, 64'd0);
    end

    for (int p = 0; p < 32; p++) begin
      run_frame(p[0] ? 2'b10 : 2'b01, 5'(p), 5'(31 - p),
                16'(p * 16'h0F0F + 16'h1234), p[1],
                16'(p * 16'h1357) ^ 16'hC3A5, (p == 5) || (p == 22));
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule